// File: doc/BRIEF.md
# Pulse-Width Sync/Data Demultiplexer

This block takes one serial line that carries a repeating frame of low-going pulses and splits it into a recovered frame clock and a set of channel levels. All logic runs on a fast system clock that oversamples the line, and a counted delay replaces an analog one-shot. A short low pulse marks the start of a frame (sync). A long low pulse carries data. The block tells them apart by looking at the line once, a fixed number of cycles after each falling edge. If the line is already high again at that point, the pulse was a sync.

For each sync the block drives a single-cycle, active-low pulse on its frame clock output. It measures the time between successive syncs and divides that period into equal phase slots, one per channel, with slot 0 starting on the sync. At the start of each slot the line level is captured into that channel's output. Until two syncs have been seen there is no period measurement, so the phase and channel outputs stay at zero and the lock flag stays low. Downstream logic reads the channel levels as plain outputs. It can use the active-low clock pulse or the lock flag to know when a frame has been refreshed.

Top module: `pulse_width_demux`

## Requirements
- R1: A low pulse on `mux_line` lasting at most `DELAY_CYC` clock cycles is a sync. `rclk_n` is low in the cycle that follows the rising edge `DELAY_CYC+2` edges after the first edge that samples `mux_line` low.
- R2: A falling edge on the synchronised line that arrives while the delay timer is running is ignored. It neither restarts nor extends the timer, and the sync timing of R1 is kept.
- R3: Each `rclk_n` low pulse lasts exactly one cycle. At all other times `rclk_n` is high.
- R4: A low pulse longer than `DELAY_CYC` cycles is data and produces no low cycle on `rclk_n`.
- R5: `locked` is 0 until the second sync is detected and 1 from then on. While `locked` is 0, `phase` and `chan` are all zero.
- R6: When locked, `phase` is one-hot. `phase[0]` starts in the same cycle as the `rclk_n` low pulse. Each slot lasts (sync-to-sync period in cycles) / `NUM_PH` cycles, and the last slot is held until the next sync.
- R7: `chan[k]` changes only one edge after `phase[k]` rises. It then takes the level `mux_line` had at the edge just before `phase[k]` rose, and it holds that level until the next rise of `phase[k]`.
- R8: Synchronous active-high `rst` clears the timer, the period measurement, `locked`, `phase` and `chan`, and holds `rclk_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the line |
| rst | input | 1 | Synchronous active-high reset |
| mux_line | input | 1 | Asynchronous multiplexed pulse line, idle high |
| rclk_n | output | 1 | Recovered frame clock, one low cycle per sync |
| phase | output | NUM_PH | One-hot phase slots aligned to the sync |
| chan | output | NUM_PH | Captured level for each channel |
| locked | output | 1 | Period measured, phase outputs valid |

## Verification
Two coincidences are provoked on purpose.

The first is a new falling edge arriving while the delay timer is still counting. Some frames carry a short second dip inside the sync window. The judgement is that `rclk_n` still falls on exactly the cycle predicted from the first edge, and that channel 0 is still captured correctly.

The second is the sync restart landing on the same edge where the last phase slot would otherwise roll over. The frame period is an exact multiple of the slot count, so both events fall on the same edge. The bench then checks `phase` every cycle against a slot index computed arithmetically from the frame offset.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

endpackage

// File: rtl/pwd_line_sync.sv
module pwd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_raw,
  output logic line_s,
  output logic fall_edge
);

  logic [STAGES-1:0] shreg;
  logic              line_d;

  // idle level of the line is high, so reset to ones to avoid a false edge
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '1;
      line_d <= 1'b1;
    end else begin
      shreg  <= {shreg[STAGES-2:0], line_raw};
      line_d <= shreg[STAGES-1];
    end
  end

  assign line_s    = shreg[STAGES-1];
  assign fall_edge = line_d & ~line_s;

endmodule

// File: rtl/pwd_width_timer.sv
module pwd_width_timer
  import pwd_pkg::*;
#(
  parameter int DELAY_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  input  logic fall_edge,
  output logic sync_stb,
  output logic rclk_n
);

  localparam int CW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);

  tmr_state_e    state;
  logic [CW-1:0] remain;
  logic          expire;

  assign expire   = (state == TMR_RUN) && (remain == '0);
  // line already back high at the end of the window: short pulse, i.e. sync
  assign sync_stb = expire && line_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TMR_IDLE;
      remain <= '0;
      rclk_n <= 1'b1;
    end else begin
      rclk_n <= ~sync_stb;
      unique case (state)
        TMR_IDLE: begin
          if (fall_edge) begin
            state  <= TMR_RUN;
            remain <= CW'(DELAY_CYC - 1);
          end
        end
        TMR_RUN: begin
          // falling edges seen here are deliberately not acted upon
          if (remain == '0) state <= TMR_IDLE;
          else              remain <= remain - 1'b1;
        end
        default: state <= TMR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwd_slot_gen.sv
module pwd_slot_gen #(
  parameter int NUM_PH = 4,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_stb,
  output logic [NUM_PH-1:0] phase,
  output logic              locked
);

  localparam int SW = (NUM_PH < 2) ? 1 : $clog2(NUM_PH);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_PH - 1);

  logic [PER_W-1:0] since;
  logic [PER_W-1:0] period;
  logic [PER_W-1:0] slot_len;
  logic [PER_W-1:0] slot_len_eff;
  logic [PER_W-1:0] slot_cnt;
  logic [SW-1:0]    slot_idx;
  logic             seen_one;
  logic             since_max;

  assign since_max    = (since == '1);
  assign slot_len     = period >> SW;
  assign slot_len_eff = (slot_len == '0) ? PER_W'(1) : slot_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      since    <= '0;
      period   <= '0;
      slot_cnt <= '0;
      slot_idx <= '0;
      seen_one <= 1'b0;
      locked   <= 1'b0;
    end else if (sync_stb) begin
      since    <= '0;
      seen_one <= 1'b1;
      slot_cnt <= '0;
      slot_idx <= '0;
      if (seen_one) begin
        period <= since_max ? since : since + 1'b1;
        locked <= 1'b1;
      end
    end else begin
      if (!since_max) since <= since + 1'b1;
      if (slot_cnt == slot_len_eff - 1'b1) begin
        slot_cnt <= '0;
        if (slot_idx != LAST_SLOT) slot_idx <= slot_idx + 1'b1;
      end else begin
        slot_cnt <= slot_cnt + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_PH; k++) begin : g_phase
    assign phase[k] = locked && (slot_idx == SW'(k));
  end

endmodule

// File: rtl/pwd_chan_latch.sv
module pwd_chan_latch #(
  parameter int NUM_PH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_s,
  input  logic [NUM_PH-1:0] phase,
  output logic [NUM_PH-1:0] chan
);

  logic [NUM_PH-1:0] phase_d;

  always_ff @(posedge clk) begin
    if (rst) phase_d <= '0;
    else     phase_d <= phase;
  end

  for (genvar k = 0; k < NUM_PH; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                        chan[k] <= 1'b0;
      else if (phase[k] & ~phase_d[k]) chan[k] <= line_s;
    end
  end

endmodule

// File: rtl/pulse_width_demux.sv
module pulse_width_demux #(
  parameter int DELAY_CYC   = 8,
  parameter int NUM_PH      = 4,
  parameter int PER_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mux_line,
  output logic              rclk_n,
  output logic [NUM_PH-1:0] phase,
  output logic [NUM_PH-1:0] chan,
  output logic              locked
);

  logic line_s;
  logic fall_edge;
  logic sync_stb;

  pwd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .line_raw  (mux_line),
    .line_s    (line_s),
    .fall_edge (fall_edge)
  );

  pwd_width_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .line_s    (line_s),
    .fall_edge (fall_edge),
    .sync_stb  (sync_stb),
    .rclk_n    (rclk_n)
  );

  pwd_slot_gen #(.NUM_PH(NUM_PH), .PER_W(PER_W)) u_slots (
    .clk      (clk),
    .rst      (rst),
    .sync_stb (sync_stb),
    .phase    (phase),
    .locked   (locked)
  );

  pwd_chan_latch #(.NUM_PH(NUM_PH)) u_lanes (
    .clk    (clk),
    .rst    (rst),
    .line_s (line_s),
    .phase  (phase),
    .chan   (chan)
  );

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int NUM_PH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rclk_n,
  input logic              locked,
  input logic [NUM_PH-1:0] phase,
  input logic [NUM_PH-1:0] chan
);

  logic [NUM_PH-1:0] phase_seen;

  always_ff @(posedge clk) begin
    if (rst) phase_seen <= '0;
    else     phase_seen <= phase;
  end

  assert_rclk_single_R3: assert property (@(posedge clk) disable iff (rst)
    !rclk_n |=> rclk_n);

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (rclk_n && !locked && phase == '0 && chan == '0));

  assert_unlocked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (phase == '0 && chan == '0));

  assert_phase_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    locked |-> ($countones(phase) == 1));

  assert_phase0_with_clock_R6: assert property (@(posedge clk) disable iff (rst)
    (!rclk_n && locked) |-> phase[0]);

  assert_chan_after_rise_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan) |-> ($past(phase & ~phase_seen) != '0));

endmodule

bind pulse_width_demux pwd_checker #(.NUM_PH(NUM_PH)) u_pwd_checker (
  .clk    (clk),
  .rst    (rst),
  .rclk_n (rclk_n),
  .locked (locked),
  .phase  (phase),
  .chan   (chan)
);

// File: tb/pulse_width_demux_bench.sv
module pulse_width_demux_bench;

  localparam int D    = 8;
  localparam int NP   = 4;
  localparam int P    = 80;
  localparam int Q    = P / NP;
  localparam int BASE = 20;
  localparam int NF   = 18;
  localparam int ENDC = BASE + NF * P + 200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mux_line = 1'b1;
  logic          rclk_n;
  logic [NP-1:0] phase;
  logic [NP-1:0] chan;
  logic          locked;
  int            cyc = 0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_width_demux #(.DELAY_CYC(D), .NUM_PH(NP), .PER_W(16), .SYNC_STAGES(2)) u_pulse_width_demux (
    .clk (clk), .rst (rst), .mux_line (mux_line),
    .rclk_n (rclk_n), .phase (phase), .chan (chan), .locked (locked)
  );

  function automatic int frame_bits(input int fr);
    return fr % 16;
  endfunction

  // line level presented to edge n
  function automatic logic line_at(input int n);
    int o;
    int fr;
    if (n < BASE) return 1'b1;
    o  = (n - BASE) % P;
    fr = (n - BASE) / P;
    if (fr >= NF) return 1'b1;
    if (o < 3) return 1'b0;                                  // sync, width 3 <= D
    if (fr % 3 == 2 && (o == 5 || o == 6)) return 1'b0;      // dip while timer runs
    for (int k = 0; k < NP; k++)
      if (!frame_bits(fr)[k] && o >= 9 + Q * k && o < 19 + Q * k) return 1'b0; // data, width 10 > D
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic check_cycle(input int m);
    int rel;
    int f;
    int r;
    int sl;
    int relk;
    int ec;
    logic exp_rclk;
    logic exp_lock;
    logic [NP-1:0] exp_ph;
    string tag;
    rel      = m - (BASE + D + 2);
    exp_rclk = !(rel >= 0 && rel % P == 0 && rel / P < NF);
    if (!exp_rclk) tag = ((rel / P) % 3 == 2) ? "R2 glitch-sync" : "R1 sync";
    else if (rel >= 0 && rel % P == 1 && rel / P < NF) tag = "R3 one-cycle";
    else tag = "R4 no-pulse";
    chk(tag, rclk_n, exp_rclk);
    exp_lock = (rel >= P);
    chk("R5 locked", locked, exp_lock);
    exp_ph = '0;
    if (exp_lock) begin
      f = rel / P;
      r = rel % P;
      if (f >= NF) r = P - 1;
      sl = r / Q;
      if (sl > NP - 1) sl = NP - 1;
      exp_ph[sl] = 1'b1;
    end
    chk("R6 phase", phase, exp_ph);
    for (int k = 0; k < NP; k++) begin
      relk = m - (BASE + D + 3 + Q * k);
      ec = 0;
      if (relk >= 0) begin
        f = relk / P;
        if (f >= NF) f = NF - 1;
        if (f >= 1) ec = frame_bits(f)[k];
      end
      chk($sformatf("R7 chan%0d", k), chan[k], ec);
    end
  endtask

  initial begin
    while (cyc < ENDC) begin
      @(negedge clk);
      if (cyc == 3) begin
        chk("R8 reset rclk_n", rclk_n, 1);
        chk("R8 reset locked", locked, 0);
        chk("R8 reset phase", phase, 0);
        chk("R8 reset chan", chan, 0);
      end
      if (cyc == 4) rst = 1'b0;
      if (!rst && cyc >= 5) check_cycle(cyc);
      mux_line = line_at(cyc + 1);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * (ENDC + 2000));
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule